// File: doc/BRIEF.md
# Format-Aligning Fixed-Point Adder/Subtractor

A purely combinational datapath that combines two signed fixed-point operands, each with its own bit width and binary exponent fixed at elaboration. An operand's integer value `v` stands for the real number `v * 2^exp`. The result is produced in a separate output format. The output width is a parameter. The output exponent is worked out at elaboration from an output range and that width, and the range is either supplied by the caller or derived from the operand formats.

Each operand is shifted into the output exponent by its own alignment stage. The aligned operands are sign-extended to the output width plus one guard bit, combined according to a two-bit mode, and the low output-width bits are driven out. Overflow therefore wraps without saturating. Callers use the block wherever two fixed-point signals in different formats must be summed or differenced without hand-placed shifts.

Top module: `fx_align_addsub`

## Requirements
- R1: The output exponent is the smallest integer `e` with `2^e >= range / (2^(OUT_WIDTH-1) - 1)`, where range is the output range in real units.
- R2: When `OUT_RANGE` is 0.0 (its default), the output range is the sum of the operand ranges. An operand's range is `(2^(width-1) - 1) * 2^exp`.
- R3: `OUT_WIDTH`, `A_WIDTH` and `B_WIDTH` default to 25 bits.
- R4: A caller-supplied `OUT_WIDTH` (for example 40) replaces the default. The range is still derived as in R2, so only the output resolution changes.
- R5: With `mode_i` = 2'b00 the output is the aligned sum a + b.
- R6: With `mode_i` = 2'b01 the output is a - b (first operand minus second), never b - a.
- R7: With `mode_i` = 2'b10 the output is the two's-complement negative of the aligned a, and `b_i` has no effect.
- R8: The code `mode_i` = 2'b11 behaves exactly as add.
- R9: An operand whose exponent is below the output exponent is arithmetically shifted right, and the dropped bits round toward negative infinity. An operand whose exponent is above the output exponent is shifted left with zero fill.
- R10: A result outside the output width wraps modulo `2^OUT_WIDTH`. This holds also when the caller gives an output range smaller than the operands can reach.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | A_WIDTH | First operand, signed, scaled by 2^A_EXP |
| b_i | input | B_WIDTH | Second operand, signed, scaled by 2^B_EXP |
| mode_i | input | 2 | 00 add, 01 subtract, 10 negate a, 11 add |
| sum_o | output | OUT_WIDTH | Signed result, scaled by the derived output exponent |

## Verification
The bench targets the following cases, which an incorrect design would get wrong:
- Small negative values of the right-shifted operand, such as -1 raw. Truncating toward zero would give 0 where the floor gives -1.
- Subtraction with distinct operands. A swapped subtractor returns the negated result.
- Negation with a non-zero b. A design that leaks b into that mode shifts the output.
- Three instances with a default width, an overridden width and a small explicit range. An error in the exponent formula or the range derivation scales every result by a power of two. A design that saturates instead of wrapping gives a wrong result at the extreme operand values in the small-range instance.

// File: rtl/fx_pkg.sv
package fx_pkg;

  typedef enum logic [1:0] {
    FX_ADD = 2'b00,
    FX_SUB = 2'b01,
    FX_NEG = 2'b10,
    FX_RSV = 2'b11
  } fx_op_e;

  // 2^e for small signed e, real result
  function automatic real fx_pow2(input int e);
    real p;
    p = 1.0;
    for (int i = 0; i < 256; i++) begin
      if (i < e) p = p * 2.0;
      if (i < -e) p = p / 2.0;
    end
    return p;
  endfunction

  // symmetric range a signed format can hold
  function automatic real fx_range(input int width, input int exp_v);
    return (fx_pow2(width - 1) - 1.0) * fx_pow2(exp_v);
  endfunction

  // smallest e with 2^e >= rng / (2^(width-1) - 1)
  function automatic int fx_exp(input real rng, input int width);
    real step;
    real p;
    int  e;
    step = rng / (fx_pow2(width - 1) - 1.0);
    p = 1.0;
    e = 0;
    for (int i = 0; i < 256; i++) begin
      if (p < step) begin
        p = p * 2.0;
        e = e + 1;
      end
    end
    for (int i = 0; i < 256; i++) begin
      if (p / 2.0 >= step) begin
        p = p / 2.0;
        e = e - 1;
      end
    end
    return e;
  endfunction

endpackage

// File: rtl/fx_align.sv
module fx_align #(
  parameter int IN_W    = 25,
  parameter int IN_EXP  = 0,
  parameter int OUT_EXP = 0,
  parameter int EXT_W   = 26
) (
  input  logic signed [IN_W-1:0]  in_i,
  output logic signed [EXT_W-1:0] out_o
);

  localparam int SH = IN_EXP - OUT_EXP;

  if (SH >= 0) begin : g_left
    logic signed [EXT_W-1:0] ext;
    assign ext   = EXT_W'(in_i);
    assign out_o = ext <<< SH;
  end else begin : g_right
    localparam int RS = -SH;
    // arithmetic shift: dropped bits floor toward -inf
    logic signed [IN_W-1:0] shr;
    assign shr   = in_i >>> RS;
    assign out_o = EXT_W'(shr);
  end

endmodule

// File: rtl/fx_addsub.sv
module fx_addsub
  import fx_pkg::*;
#(
  parameter int OUT_W = 25,
  parameter int EXT_W = 26
) (
  input  logic signed [EXT_W-1:0] x_i,
  input  logic signed [EXT_W-1:0] y_i,
  input  logic        [1:0]       mode_i,
  output logic signed [OUT_W-1:0] sum_o
);

  fx_op_e                  op;
  logic signed [EXT_W-1:0] r;

  assign op = fx_op_e'(mode_i);

  always_comb begin
    unique case (op)
      FX_SUB:  r = x_i - y_i;
      FX_NEG:  r = -x_i;
      default: r = x_i + y_i;
    endcase
  end

  // guard bit dropped: overflow wraps
  assign sum_o = OUT_W'(r);

endmodule

// File: rtl/fx_align_addsub.sv
module fx_align_addsub
  import fx_pkg::*;
#(
  parameter int  A_WIDTH   = 25,
  parameter int  A_EXP     = -20,
  parameter int  B_WIDTH   = 25,
  parameter int  B_EXP     = -20,
  parameter int  OUT_WIDTH = 25,
  parameter real OUT_RANGE = 0.0
) (
  input  logic signed [A_WIDTH-1:0]   a_i,
  input  logic signed [B_WIDTH-1:0]   b_i,
  input  logic        [1:0]           mode_i,
  output logic signed [OUT_WIDTH-1:0] sum_o
);

  localparam real A_RANGE = fx_range(A_WIDTH, A_EXP);
  localparam real B_RANGE = fx_range(B_WIDTH, B_EXP);
  localparam real OUT_RNG = (OUT_RANGE > 0.0) ? OUT_RANGE : A_RANGE + B_RANGE;
  localparam int  OUT_EXP = fx_exp(OUT_RNG, OUT_WIDTH);
  localparam int  EXT_W   = OUT_WIDTH + 1;

  logic signed [EXT_W-1:0] a_al;
  logic signed [EXT_W-1:0] b_al;

  fx_align #(
    .IN_W   (A_WIDTH),
    .IN_EXP (A_EXP),
    .OUT_EXP(OUT_EXP),
    .EXT_W  (EXT_W)
  ) i_align_a (
    .in_i (a_i),
    .out_o(a_al)
  );

  fx_align #(
    .IN_W   (B_WIDTH),
    .IN_EXP (B_EXP),
    .OUT_EXP(OUT_EXP),
    .EXT_W  (EXT_W)
  ) i_align_b (
    .in_i (b_i),
    .out_o(b_al)
  );

  fx_addsub #(
    .OUT_W(OUT_WIDTH),
    .EXT_W(EXT_W)
  ) i_addsub (
    .x_i   (a_al),
    .y_i   (b_al),
    .mode_i(mode_i),
    .sum_o (sum_o)
  );

endmodule

// File: rtl/fx_align_addsub_chk.sv
module fx_align_addsub_chk #(
  parameter int OW = 25
) (
  input logic [OW-1:0] a_lo_i,
  input logic [OW-1:0] b_lo_i,
  input logic [1:0]    mode_i,
  input logic [OW-1:0] sum_i
);

  logic [OW-1:0] diff_b;
  logic [OW-1:0] plus_b;
  logic [OW-1:0] plus_a;

  assign diff_b = sum_i - b_lo_i;
  assign plus_b = sum_i + b_lo_i;
  assign plus_a = sum_i + a_lo_i;

  always_comb begin
    // R5
    add_mode_chk: assert (mode_i != 2'b00 || diff_b == a_lo_i)
      else $error("add mode result inconsistent");
    // R6
    sub_order_chk: assert (mode_i != 2'b01 || plus_b == a_lo_i)
      else $error("sub mode not a minus b");
    // R7
    neg_mode_chk: assert (mode_i != 2'b10 || plus_a == '0)
      else $error("neg mode not negative of a");
    // R8
    rsv_as_add_chk: assert (mode_i != 2'b11 || diff_b == a_lo_i)
      else $error("code 11 not add");
  end

endmodule

bind fx_align_addsub fx_align_addsub_chk #(
  .OW(OUT_WIDTH)
) i_chk (
  .a_lo_i(a_al[OUT_WIDTH-1:0]),
  .b_lo_i(b_al[OUT_WIDTH-1:0]),
  .mode_i(mode_i),
  .sum_i (sum_o)
);

// File: tb/test_fx_align_addsub.sv
module test_fx_align_addsub;

  localparam int AW = 25;
  localparam int AE = -21;
  localparam int BW = 16;
  localparam int BE = -11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic signed [AW-1:0] a;
  logic signed [BW-1:0] b;
  logic        [1:0]    mode;
  logic signed [24:0]   sum0;
  logic signed [39:0]   sum1;
  logic signed [11:0]   sum2;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // default output width, derived range
  fx_align_addsub #(.A_WIDTH(AW), .A_EXP(AE), .B_WIDTH(BW), .B_EXP(BE)) i_fx_align_addsub (
    .a_i(a), .b_i(b), .mode_i(mode), .sum_o(sum0));
  // widened output, derived range
  fx_align_addsub #(.A_WIDTH(AW), .A_EXP(AE), .B_WIDTH(BW), .B_EXP(BE),
    .OUT_WIDTH(40)) i_fx_align_addsub_w40 (
    .a_i(a), .b_i(b), .mode_i(mode), .sum_o(sum1));
  // narrow explicit range: wraps
  fx_align_addsub #(.A_WIDTH(AW), .A_EXP(AE), .B_WIDTH(BW), .B_EXP(BE),
    .OUT_WIDTH(12), .OUT_RANGE(4.0)) i_fx_align_addsub_r4 (
    .a_i(a), .b_i(b), .mode_i(mode), .sum_o(sum2));

  function automatic int exp_of(real rng, int w);
    return int'($ceil($ln(rng / ($pow(2.0, w - 1) - 1.0)) / $ln(2.0)));
  endfunction

  function automatic real rng_of(int w, int e);
    return ($pow(2.0, w - 1) - 1.0) * $pow(2.0, e);
  endfunction

  function automatic longint to_exp(longint v, int ei, int eo);
    if (ei >= eo) return v <<< (ei - eo);
    return v >>> (eo - ei);  // floor toward -inf
  endfunction

  function automatic longint model(longint av, longint bv, logic [1:0] m, int eo, int ow);
    longint x, y, r;
    x = to_exp(av, AE, eo);
    y = to_exp(bv, BE, eo);
    case (m)
      2'b01:   r = x - y;
      2'b10:   r = -x;
      default: r = x + y;
    endcase
    return (r <<< (64 - ow)) >>> (64 - ow);
  endfunction

  int eo0, eo1, eo2;

  task automatic check(string tag, longint got, longint exp_v);
    checks++;
    if (got != exp_v) begin
      errors++;
      $display("FAIL %s: a=%0d b=%0d mode=%0d got=%0d expected=%0d", tag, a, b, mode, got, exp_v);
    end
  endtask

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00: return "R5";
      2'b01: return "R6";
      2'b10: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(logic signed [AW-1:0] av, logic signed [BW-1:0] bv, logic [1:0] m);
    real exact, got_r;
    @(posedge clk);
    a = av; b = bv; mode = m;
    @(negedge clk);
    check({mode_tag(m), " R1 R2 R3 R9 w25"}, longint'(sum0), model(longint'(av), longint'(bv), m, eo0, 25));
    check({mode_tag(m), " R4 w40"}, longint'(sum1), model(longint'(av), longint'(bv), m, eo1, 40));
    check({mode_tag(m), " R10 w12"}, longint'(sum2), model(longint'(av), longint'(bv), m, eo2, 12));
    // R4: all shifts are left in the 40-bit format, real result exact to 1 LSB
    case (m)
      2'b01:   exact = real'(av) * $pow(2.0, AE) - real'(bv) * $pow(2.0, BE);
      2'b10:   exact = -real'(av) * $pow(2.0, AE);
      default: exact = real'(av) * $pow(2.0, AE) + real'(bv) * $pow(2.0, BE);
    endcase
    got_r = real'(sum1) * $pow(2.0, eo1);
    checks++;
    if ((got_r - exact > $pow(2.0, eo1)) || (exact - got_r > $pow(2.0, eo1))) begin
      errors++;
      $display("FAIL R4 real: got=%f expected=%f", got_r, exact);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    eo0 = exp_of(rng_of(AW, AE) + rng_of(BW, BE), 25);
    eo1 = exp_of(rng_of(AW, AE) + rng_of(BW, BE), 40);
    eo2 = exp_of(4.0, 12);
    a = '0; b = '0; mode = 2'b00;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state: zero in, zero out
    check("R5 reset w25", longint'(sum0), 0);
    check("R4 reset w40", longint'(sum1), 0);

    // R9: small negatives of the right-shifted operand floor to -1
    apply(-25'sd1, 16'sd0, 2'b00);
    apply(-25'sd3, 16'sd0, 2'b00);
    apply(25'sd5, 16'sd0, 2'b00);
    apply(-25'sd4, 16'sd1, 2'b00);
    // R6: order of subtraction
    apply(25'sd400000, 16'sd100, 2'b01);
    apply(25'sd400000, -16'sd100, 2'b01);
    // R7: b must not matter
    apply(25'sd1234567, 16'sd32767, 2'b10);
    apply(25'sd1234567, -16'sd32767, 2'b10);
    apply(-25'sd1, 16'sd77, 2'b10);
    // R8
    apply(25'sd99999, -16'sd2222, 2'b11);
    // R10: extremes wrap in the narrow instance
    apply(25'sd16777215, 16'sd32767, 2'b00);
    apply(-25'sd16777215, -16'sd32767, 2'b00);
    apply(25'sd16777215, -16'sd32767, 2'b01);

    for (int i = 0; i < 400; i++) begin
      logic signed [AW-1:0] ra;
      logic signed [BW-1:0] rb;
      ra = AW'($urandom);
      rb = BW'($urandom);
      if (ra == {1'b1, {(AW-1){1'b0}}}) ra = '0;
      if (rb == {1'b1, {(BW-1){1'b0}}}) rb = '0;
      apply(ra, rb, 2'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule